// File: doc/BRIEF.md
# Protected Clock Output Divider Register

This block is an 8-bit control register with a clock-output generator behind it. Software writes the register over a simple single-cycle bus. A write only lands while a short timed-access window is open, and a two-byte unlock sequence sent to a separate address opens that window. The register is always readable on `bus_rdata`.

When the output enable bit is set, the output pin carries a generated clock. One source is the system clock divided by 2, 4, 6 or 8, always with a 50% duty cycle. The other source is a 16x serial baud tick supplied from outside, and it takes priority over the divide setting. When the enable is clear, the pin follows a general-purpose output value.

Two further register bits hold the high-order prescaler bits for a neighbouring controller. They change only when an external permission input allows it. A new source or ratio is applied only while the generated clock is low, so every high phase on the pin runs its full length.

Top module: `clkout_ctl_reg`

## Requirements
- R1: After reset the register reads 8'h00, `presc_hi` is 0 and `clk_pin` equals `gpio_val`.
- R2: Two writes to address 0 open the timed-access window: 8'hAA in one cycle, then 8'h55 in the very next cycle. The window accepts register writes (address 1) in the 4 cycles that follow the 8'h55 cycle, and rejects them after that. If any cycle separates the two keys, or if 8'h55 is written alone, no window opens.
- R3: A register write made while no window is open is discarded, and the register keeps its previous contents.
- R4: The register bit layout is as follows:
  - bit 0 is the output enable;
  - bits 2:1 are the divide select;
  - bits 4:3 are the prescaler high bits, driven on `presc_hi`;
  - bit 7 is the 16x select;
  - bits 6:5 always read 0.
- R5: In an accepted write with `presc_wr_ok` = 0, bits 4:3 keep their old value while the other fields update. With `presc_wr_ok` = 1, all fields update.
- R6: While the enable is 0, `clk_pin` equals `gpio_val` whatever bits 7 and 2:1 hold. This takes effect once the current high phase has ended.
- R7: With enable = 1 and 16x select = 0, the divide select sets the period: 00 gives 2 system clocks, 01 gives 4, 10 gives 6 and 11 gives 8. The output is high for half the period and low for half.
- R8: With enable = 1 and 16x select = 1, the output toggles on each cycle where `baud16_tick` is 1. Each phase therefore lasts one tick interval, and the divide select is ignored.
- R9: A change of source or ratio is applied only while the output is low. Every high phase lasts the full half period of the setting that was active when it began.
- R10: `bus_rdata` shows an accepted write in the cycle after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Write address: 0 = unlock, 1 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register contents |
| presc_wr_ok | input | 1 | Permission to change the prescaler high bits |
| baud16_tick | input | 1 | Single-cycle 16x baud enable tick |
| gpio_val | input | 1 | General-purpose value driven when the clock output is off |
| clk_pin | output | 1 | Output pin value |
| presc_hi | output | 2 | Prescaler high bits for the neighbouring controller |

## Verification
Register results appear one edge after the write is captured. The bench therefore drives writes at the falling edge and reads `bus_rdata` at the next falling edge. The window boundary is probed by placing the register write exactly 3 and 4 idle cycles after the unlock: the first write must land and the second must be rejected.

A new pin setting waits for a low phase and then for one full half period. For this reason the bench lets each new setting settle for many cycles before it samples the pin. It then measures whole high and low runs at falling edges instead of checking single cycles. During a live change from divide-by-8 to divide-by-2, every high run is checked to be either 4 or 1 system clocks long.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    localparam int REG_W  = 8;
    localparam int DIV_W  = 2;
    localparam int HALF_W = 3;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_DIV  = 2'd1,
        SRC_BAUD = 2'd2
    } src_e;

    typedef struct packed {
        logic             sel16;
        logic [1:0]       presc;
        logic [DIV_W-1:0] divsel;
        logic             en;
    } ctl_t;

    typedef struct packed {
        src_e             src;
        logic [DIV_W-1:0] divsel;
    } plan_t;

    function automatic plan_t plan_of(ctl_t c);
        plan_t p;
        if (!c.en) begin
            p.src    = SRC_OFF;
            p.divsel = '0;
        end else if (c.sel16) begin
            p.src    = SRC_BAUD;
            p.divsel = '0;
        end else begin
            p.src    = SRC_DIV;
            p.divsel = c.divsel;
        end
        return p;
    endfunction

    function automatic logic [HALF_W-1:0] half_of(logic [DIV_W-1:0] d);
        return HALF_W'(d) + HALF_W'(1);
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(ctl_t c);
        return {c.sel16, 2'b00, c.presc, c.divsel, c.en};
    endfunction
endpackage

// File: rtl/ta_gate.sv
module ta_gate #(
    parameter int          ADDR_W      = 2,
    parameter int          WIN_CYC     = 4,
    parameter logic [7:0]  KEY_A       = 8'hAA,
    parameter logic [7:0]  KEY_B       = 8'h55,
    parameter int          UNLOCK_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              win_open
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);

    logic             armed;
    logic [CNT_W-1:0] win_cnt;
    logic             key_hit;

    assign key_hit  = bus_wr && (bus_addr == ADDR_W'(UNLOCK_ADDR));
    assign win_open = (win_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            win_cnt <= '0;
        end else begin
            armed <= key_hit && (bus_wdata == KEY_A);
            if (key_hit && armed && (bus_wdata == KEY_B))
                win_cnt <= CNT_W'(WIN_CYC);
            else if (win_cnt != '0)
                win_cnt <= win_cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/cor_regfile.sv
module cor_regfile
    import clkout_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int REG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              win_open,
    input  logic              presc_wr_ok,
    output ctl_t              ctl
);
    logic accept;
    logic unused_rsvd;

    assign accept      = bus_wr && win_open && (bus_addr == ADDR_W'(REG_ADDR));
    assign unused_rsvd = ^bus_wdata[6:5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (accept) begin
            ctl.en     <= bus_wdata[0];
            ctl.divsel <= bus_wdata[2:1];
            ctl.sel16  <= bus_wdata[7];
            if (presc_wr_ok)
                ctl.presc <= bus_wdata[4:3];
        end
    end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  plan_t want,
    input  logic  baud_tick,
    output logic  clk_q,
    output plan_t active
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;

    assign half = half_of(active.divsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '{src: SRC_OFF, divsel: '0};
            clk_q  <= 1'b0;
            cnt    <= '0;
        end else if (!clk_q && (want != active)) begin
            active <= want;
            cnt    <= '0;
        end else begin
            unique case (active.src)
                SRC_DIV: begin
                    if (cnt == half - HALF_W'(1)) begin
                        clk_q <= ~clk_q;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                SRC_BAUD: begin
                    if (baud_tick)
                        clk_q <= ~clk_q;
                end
                default: begin
                    clk_q <= 1'b0;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clkout_ctl_reg.sv
module clkout_ctl_reg
    import clkout_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int WIN_CYC     = 4,
    parameter int UNLOCK_ADDR = 0,
    parameter int REG_ADDR    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              presc_wr_ok,
    input  logic              baud16_tick,
    input  logic              gpio_val,
    output logic              clk_pin,
    output logic [1:0]        presc_hi
);
    logic              win_open;
    ctl_t              ctl;
    plan_t             active;
    logic              clk_q;
    src_e              act_src;
    logic [HALF_W-1:0] act_half;

    ta_gate #(
        .ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC),
        .KEY_A(8'hAA), .KEY_B(8'h55), .UNLOCK_ADDR(UNLOCK_ADDR)
    ) u_gate (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .win_open(win_open)
    );

    cor_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .win_open(win_open),
        .presc_wr_ok(presc_wr_ok), .ctl(ctl)
    );

    clkout_gen u_gen (
        .clk(clk), .rst(rst), .want(plan_of(ctl)), .baud_tick(baud16_tick),
        .clk_q(clk_q), .active(active)
    );

    assign act_src   = active.src;
    assign act_half  = half_of(active.divsel);
    assign bus_rdata = pack_ctl(ctl);
    assign presc_hi  = ctl.presc;
    assign clk_pin   = (active.src == SRC_OFF) ? gpio_val : clk_q;
endmodule

// File: rtl/clkout_chk.sv
module clkout_chk
    import clkout_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_rdata,
    input logic              presc_wr_ok,
    input logic              win_open,
    input logic              clk_q,
    input src_e              act_src,
    input logic [HALF_W-1:0] act_half,
    input logic              baud16_tick
);
    logic [HALF_W:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)
            hi_len <= '0;
        else if (!clk_q)
            hi_len <= '0;
        else if (hi_len != '1)
            hi_len <= hi_len + 1'b1;
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> $stable(bus_rdata)); // R3

    AST_PRESC_GUARD: assert property (@(posedge clk) disable iff (rst)
        !presc_wr_ok |=> $stable(bus_rdata[4:3])); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[6:5] == 2'b00); // R4

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_OFF) |=> !clk_q); // R6

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_q) && act_src == SRC_DIV) |-> (hi_len == {1'b0, act_half})); // R9

    AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_BAUD && !baud16_tick) |=> $stable(clk_q)); // R8
endmodule

bind clkout_ctl_reg clkout_chk i_chk (
    .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .presc_wr_ok(presc_wr_ok),
    .win_open(win_open), .clk_q(clk_q), .act_src(act_src),
    .act_half(act_half), .baud16_tick(baud16_tick)
);

// File: tb/test_clkout_ctl_reg.sv
module test_clkout_ctl_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       presc_wr_ok = 1'b0;
    logic       baud16_tick = 1'b0;
    logic       gpio_val = 1'b0;
    logic       clk_pin;
    logic [1:0] presc_hi;

    int n_chk = 0;
    int n_fail = 0;
    int tick_per = 0;
    bit done = 1'b0;

    clkout_ctl_reg i_clkout_ctl_reg (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .presc_wr_ok(presc_wr_ok), .baud16_tick(baud16_tick),
        .gpio_val(gpio_val), .clk_pin(clk_pin), .presc_hi(presc_hi)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(logic [7:0] old, logic [7:0] d, bit perm);
        return {d[7], 2'b00, perm ? d[4:3] : old[4:3], d[2:1], d[0]};
    endfunction

    initial begin : ticker
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            if (tick_per > 0) begin
                tcnt++;
                if (tcnt >= tick_per) begin
                    baud16_tick = 1'b1;
                    tcnt = 0;
                end else begin
                    baud16_tick = 1'b0;
                end
            end else begin
                baud16_tick = 1'b0;
                tcnt = 0;
            end
        end
    end

    task automatic bus_put(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic unlock();
        bus_put(2'd0, 8'hAA);
        bus_put(2'd0, 8'h55);
    endtask

    task automatic prot_wr(input logic [7:0] d);
        unlock();
        bus_put(2'd1, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        hi = -1; lo = -1;
        g = 0;
        while (clk_pin !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        g = 0;
        while (clk_pin !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        hi = 0;
        while (clk_pin === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        lo = 0;
        while (clk_pin === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..all actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int hi, lo;
        logic [7:0] cur, d, want;
        logic [1:0] sel;
        bit perm, stable_ok;
        void'($urandom(32'd1234));

        // R1 reset state
        idle(3);
        check(bus_rdata == 8'h00, "R1 reset rdata", bus_rdata, 0);
        check(presc_hi == 2'b00, "R1 reset presc_hi", presc_hi, 0);
        gpio_val = 1'b1; #1;
        check(clk_pin == 1'b1, "R1 pin follows gpio high", clk_pin, 1);
        gpio_val = 1'b0; #1;
        check(clk_pin == 1'b0, "R1 pin follows gpio low", clk_pin, 0);
        @(negedge clk); rst = 1'b0; idle(2);

        // R3 write without unlock
        bus_put(2'd1, 8'h01); idle(1);
        check(bus_rdata == 8'h00, "R3 locked write discarded", bus_rdata, 0);

        // R2 keys separated by a cycle, and 8'h55 alone
        bus_put(2'd0, 8'hAA); idle(1); bus_put(2'd0, 8'h55);
        bus_put(2'd1, 8'h01);
        check(bus_rdata == 8'h00, "R2 gapped keys open nothing", bus_rdata, 0);
        bus_put(2'd0, 8'h55); bus_put(2'd1, 8'h01);
        check(bus_rdata == 8'h00, "R2 lone second key opens nothing", bus_rdata, 0);

        // R2 window boundary
        unlock(); idle(4); bus_put(2'd1, 8'h03);
        check(bus_rdata == 8'h00, "R2 write 5th cycle rejected", bus_rdata, 0);
        unlock(); idle(3); bus_put(2'd1, 8'h01);
        check(bus_rdata == 8'h01, "R2 R10 write 4th cycle accepted", bus_rdata, 1);
        cur = 8'h01;

        // R7 all four ratios directed, then random
        for (int i = 0; i < 10; i++) begin
            sel = (i < 4) ? 2'(i) : 2'($urandom % 4);
            want = {5'b0, sel, 1'b1};
            prot_wr(want);
            check(bus_rdata == want, "R10 rdata after write", bus_rdata, want);
            cur = want;
            idle(20);
            measure(hi, lo);
            check(hi == int'(sel) + 1, "R7 high half period", hi, int'(sel) + 1);
            check(lo == int'(sel) + 1, "R7 low half period", lo, int'(sel) + 1);
        end

        // R4 R5 random field writes with random permission
        for (int i = 0; i < 10; i++) begin
            d = 8'($urandom);
            d[7] = 1'b0;
            perm = bit'($urandom % 2);
            presc_wr_ok = perm;
            want = exp_reg(cur, d, perm);
            prot_wr(d);
            check(bus_rdata == want, "R4 R5 field layout", bus_rdata, want);
            check(presc_hi == want[4:3], "R4 presc_hi output", presc_hi, want[4:3]);
            cur = want;
        end
        presc_wr_ok = 1'b1; prot_wr(8'h19);
        presc_wr_ok = 1'b0; prot_wr(8'h01);
        check(presc_hi == 2'b11, "R5 presc bits held without permission", presc_hi, 3);
        check(bus_rdata == 8'h19, "R5 other fields still updated", bus_rdata, 8'h19);
        presc_wr_ok = 1'b1; prot_wr(8'h01);
        check(presc_hi == 2'b00, "R5 presc bits written with permission", presc_hi, 0);
        presc_wr_ok = 1'b0;

        // R8 baud source overrides divide select
        tick_per = 5;
        prot_wr(8'h87); idle(30);
        measure(hi, lo);
        check(hi == 5, "R8 baud high phase", hi, 5);
        check(lo == 5, "R8 baud low phase", lo, 5);
        tick_per = 3; idle(20);
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R8 baud follows tick rate", hi, 3);

        // R6 disabled output with 16x select still set
        prot_wr(8'h86); idle(20);
        stable_ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            gpio_val = bit'(i % 2); #1;
            if (clk_pin !== gpio_val) stable_ok = 1'b0;
            @(negedge clk);
        end
        check(stable_ok, "R6 pin follows gpio while disabled", clk_pin, gpio_val);
        tick_per = 0;

        // R9 live change from divide-by-8 to divide-by-2
        prot_wr(8'h07); idle(20);
        while (clk_pin !== 1'b0) @(negedge clk);
        fork
            begin : mon
                int len, bad, last;
                bad = 0; last = 0;
                for (int r = 0; r < 6; r++) begin
                    while (clk_pin !== 1'b1) @(negedge clk);
                    len = 0;
                    while (clk_pin === 1'b1 && len < 50) begin len++; @(negedge clk); end
                    if (len != 1 && len != 4) bad = len;
                    last = len;
                end
                check(bad == 0, "R9 no runt high phase", bad, 0);
                check(last == 1, "R9 new ratio applied", last, 1);
            end
            begin : wr
                @(negedge clk);
                while (clk_pin !== 1'b1) @(negedge clk);
                prot_wr(8'h01);
            end
        join

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule